// File: doc/BRIEF.md
# Tiled Embedded-DRAM Refresh Scheduler

This block decides when, and which, rows of a tiled embedded DRAM get refreshed. Every tile has its own refresh interval, counted in ticks of an external timebase strobe. Configuration software loads these intervals from the measured retention of each tile, so tiles with strong cells are refreshed rarely and weak tiles often. A per-tile hot flag halves the interval of a tile that runs warm. A per-row valid mask marks the lines that hold live data. Rows whose mask bit is clear are passed over and counted as skipped, and no refresh is spent on them.

When a tile's countdown expires, the tile becomes due. A round-robin arbiter hands one due tile at a time to a row walker. The walker steps through the tile's rows in ascending order. For every live row it presents a request on a single refresh port, using a valid/ready handshake. The memory's refresh engine consumes those requests. Tiles that have never had an interval written stay silent.

Top module: `tile_refresh_ctrl`

## Requirements
- R1: During and after a synchronous reset, req_valid is 0 and skip_count is 0. All valid-mask bits are cleared, nothing is due, and the arbiter's most recent grant is taken to be the highest-numbered tile, so tile 0 has first priority.
- R2: Writing interval N to a tile whose hot flag is 0 loads its countdown. The tile becomes due on the Nth tick strobe after the write, and again every N ticks after that. An interval of 0 behaves as 1.
- R3: If a tile's temp_hot bit is 1 when its countdown is loaded or reloaded, the count used is N shifted right by one, with a minimum of 1.
- R4: A granted tile is walked from row 0 up to row ROWS-1 in ascending order. A request is issued only for rows whose mask bit is 1.
- R5: Each row with a clear mask bit issues no request and adds exactly one to skip_count, which saturates at its maximum value.
- R6: Due tiles are served one whole tile at a time, in round-robin order that starts just after the last granted tile. A tile that becomes due again while it is already pending or being walked is served once more, after the other pending tiles.
- R7: Once req_valid is 1, it stays at 1 with req_tile and req_row unchanged until a cycle in which req_ready is 1.
- R8: A tile that has no interval written since reset never becomes due, and causes no requests and no skips.
- R9: A mask write (mask_we=1) sets the bit of the tile and row it addresses to mask_bit. The change governs every later scan of that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Refresh timebase strobe, one countdown step per high cycle |
| cfg_we | input | 1 | Interval write strobe |
| cfg_tile | input | TILE_W | Tile the interval write addresses |
| cfg_interval | input | INTERVAL_W | Interval value in ticks |
| mask_we | input | 1 | Valid-mask write strobe |
| mask_tile | input | TILE_W | Tile the mask write addresses |
| mask_row | input | ROW_W | Row the mask write addresses |
| mask_bit | input | 1 | New mask value, 1 = row holds live data |
| temp_hot | input | NUM_TILES | Per-tile hot flag |
| req_valid | output | 1 | Refresh request present |
| req_ready | input | 1 | Refresh engine accepts the request |
| req_tile | output | TILE_W | Tile of the requested row |
| req_row | output | ROW_W | Row within the tile |
| skip_count | output | SKIP_W | Number of rows passed over as not live |

## Verification
The hold property assumes that the consumer eventually raises req_ready. It also assumes that a mask bit stays unchanged during the single scan cycle in which the walker reads it. The stimulus only writes masks while the targeted tile is idle, and it always answers requests within a few cycles. The check that a rising request comes from a live row compares the mask one cycle back, and it relies on the bench never rewriting the row that is being scanned. The bench sweeps every interval from 0 to 6 with the hot flag off and on, and it works out each expected due tick by arithmetic.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_SCAN = 2'd1,
        WK_REQ  = 2'd2
    } walk_state_e;

    // Effective countdown: halved when hot, never below one tick.
    function automatic logic [31:0] eff_ticks(input logic [31:0] iv, input logic hot);
        logic [31:0] e;
        e = hot ? (iv >> 1) : iv;
        if (e == 32'd0) e = 32'd1;
        return e;
    endfunction

endpackage

// File: rtl/tile_timer.sv
module tile_timer #(
    parameter int INTERVAL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  cfg_load,
    input  logic [INTERVAL_W-1:0] cfg_value,
    input  logic                  hot,
    input  logic                  clear,
    output logic                  programmed,
    output logic                  due
);
    import refresh_pkg::*;

    logic [INTERVAL_W-1:0] interval_q;
    logic [INTERVAL_W-1:0] cnt_q;
    logic                  prog_q;
    logic                  pend_q;
    logic                  expire;

    assign expire = prog_q && tick && !cfg_load && (cnt_q <= INTERVAL_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q <= '0;
            cnt_q      <= '0;
            prog_q     <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            if (cfg_load) begin
                interval_q <= cfg_value;
                cnt_q      <= INTERVAL_W'(eff_ticks(32'(cfg_value), hot));
                prog_q     <= 1'b1;
            end else if (prog_q && tick) begin
                if (cnt_q <= INTERVAL_W'(1))
                    cnt_q <= INTERVAL_W'(eff_ticks(32'(interval_q), hot));
                else
                    cnt_q <= cnt_q - 1'b1;
            end
            pend_q <= expire | (pend_q & ~clear);
        end
    end

    assign programmed = prog_q;
    assign due        = pend_q;

    assert_due_needs_cfg_R8: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> prog_q);

    assert_count_live_R2: assert property (@(posedge clk) disable iff (rst)
        prog_q |-> (cnt_q != '0));

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    input  logic                 take,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] grant_idx,
    output logic                 any
);
    localparam int IDX_W = $clog2(N);
    localparam logic [IDX_W:0] NWIDE = (IDX_W+1)'(N);

    logic [IDX_W-1:0] last_q;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int k = 1; k <= N; k++) begin
            logic [IDX_W:0] c;
            c = {1'b0, last_q} + (IDX_W+1)'(k);
            if (c >= NWIDE) c = c - NWIDE;
            if (!any && req[c[IDX_W-1:0]]) begin
                any                   = 1'b1;
                grant[c[IDX_W-1:0]]   = 1'b1;
                grant_idx             = c[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IDX_W'(N-1);
        else if (take && any)
            last_q <= grant_idx;
    end

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_requested_R6: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/row_walker.sv
module row_walker #(
    parameter int NUM_TILES = 16,
    parameter int ROWS      = 64,
    parameter int SKIP_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         any_due,
    input  logic [$clog2(NUM_TILES)-1:0] grant_idx,
    input  logic                         row_live,
    input  logic                         req_ready,
    output logic                         take,
    output logic [$clog2(NUM_TILES)-1:0] cur_tile,
    output logic [$clog2(ROWS)-1:0]      cur_row,
    output logic                         req_valid,
    output logic [SKIP_W-1:0]            skip_count
);
    import refresh_pkg::*;

    localparam int TILE_W = $clog2(NUM_TILES);
    localparam int ROW_W  = $clog2(ROWS);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS-1);

    walk_state_e       state_q;
    logic [TILE_W-1:0] tile_q;
    logic [ROW_W-1:0]  row_q;
    logic [SKIP_W-1:0] skip_q;

    assign take = (state_q == WK_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_IDLE;
            tile_q  <= '0;
            row_q   <= '0;
            skip_q  <= '0;
        end else begin
            unique case (state_q)
                WK_IDLE: begin
                    if (any_due) begin
                        tile_q  <= grant_idx;
                        row_q   <= '0;
                        state_q <= WK_SCAN;
                    end
                end
                WK_SCAN: begin
                    if (row_live) begin
                        state_q <= WK_REQ;
                    end else begin
                        if (skip_q != '1) skip_q <= skip_q + 1'b1;
                        if (row_q == LAST_ROW) state_q <= WK_IDLE;
                        else row_q <= row_q + 1'b1;
                    end
                end
                WK_REQ: begin
                    if (req_ready) begin
                        if (row_q == LAST_ROW) begin
                            state_q <= WK_IDLE;
                        end else begin
                            row_q   <= row_q + 1'b1;
                            state_q <= WK_SCAN;
                        end
                    end
                end
                default: state_q <= WK_IDLE;
            endcase
        end
    end

    assign cur_tile   = tile_q;
    assign cur_row    = row_q;
    assign req_valid  = (state_q == WK_REQ);
    assign skip_count = skip_q;

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(cur_tile) && $stable(cur_row)));

    assert_skip_step_R5: assert property (@(posedge clk) disable iff (rst)
        (skip_count == $past(skip_count)) || (skip_count == $past(skip_count) + 1'b1));

    assert_row_ascends_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q != WK_IDLE && $past(state_q) != WK_IDLE) |-> (cur_row >= $past(cur_row)));

endmodule

// File: rtl/tile_refresh_ctrl.sv
module tile_refresh_ctrl #(
    parameter int NUM_TILES  = 16,
    parameter int ROWS       = 64,
    parameter int INTERVAL_W = 16,
    parameter int SKIP_W     = 16,
    localparam int TILE_W    = $clog2(NUM_TILES),
    localparam int ROW_W     = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  cfg_we,
    input  logic [TILE_W-1:0]     cfg_tile,
    input  logic [INTERVAL_W-1:0] cfg_interval,
    input  logic                  mask_we,
    input  logic [TILE_W-1:0]     mask_tile,
    input  logic [ROW_W-1:0]      mask_row,
    input  logic                  mask_bit,
    input  logic [NUM_TILES-1:0]  temp_hot,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [TILE_W-1:0]     req_tile,
    output logic [ROW_W-1:0]      req_row,
    output logic [SKIP_W-1:0]     skip_count
);

    logic [NUM_TILES-1:0][ROWS-1:0] mask_q;
    logic [NUM_TILES-1:0]           due;
    logic [NUM_TILES-1:0]           prog;
    logic [NUM_TILES-1:0]           grant;
    logic [TILE_W-1:0]              grant_idx;
    logic                           any_due;
    logic                           take;
    logic [TILE_W-1:0]              cur_tile;
    logic [ROW_W-1:0]               cur_row;
    logic                           row_live;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (mask_we)
            mask_q[mask_tile][mask_row] <= mask_bit;
    end

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_timer
        tile_timer #(.INTERVAL_W(INTERVAL_W)) u_timer (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .cfg_load   (cfg_we && (cfg_tile == TILE_W'(t))),
            .cfg_value  (cfg_interval),
            .hot        (temp_hot[t]),
            .clear      (take && grant[t]),
            .programmed (prog[t]),
            .due        (due[t])
        );
    end

    rr_arbiter #(.N(NUM_TILES)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (due),
        .take      (take),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (any_due)
    );

    assign row_live = mask_q[cur_tile][cur_row];

    row_walker #(.NUM_TILES(NUM_TILES), .ROWS(ROWS), .SKIP_W(SKIP_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .any_due    (any_due),
        .grant_idx  (grant_idx),
        .row_live   (row_live),
        .req_ready  (req_ready),
        .take       (take),
        .cur_tile   (cur_tile),
        .cur_row    (cur_row),
        .req_valid  (req_valid),
        .skip_count (skip_count)
    );

    assign req_tile = cur_tile;
    assign req_row  = cur_row;

    assert_req_programmed_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> prog[req_tile]);

    assert_req_live_row_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(mask_q[req_tile][req_row]));

endmodule

// File: tb/tb_tile_refresh_ctrl.sv
module tb_tile_refresh_ctrl;
    localparam int NT = 16;
    localparam int NR = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_tile = '0;
    logic [15:0] cfg_interval = '0;
    logic        mask_we = 1'b0;
    logic [3:0]  mask_tile = '0;
    logic [5:0]  mask_row = '0;
    logic        mask_bit = 1'b0;
    logic [15:0] temp_hot = '0;
    logic        req_ready = 1'b0;
    logic        req_valid;
    logic [3:0]  req_tile;
    logic [5:0]  req_row;
    logic [15:0] skip_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tile_refresh_ctrl dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cfg_we(cfg_we), .cfg_tile(cfg_tile), .cfg_interval(cfg_interval),
        .mask_we(mask_we), .mask_tile(mask_tile), .mask_row(mask_row), .mask_bit(mask_bit),
        .temp_hot(temp_hot), .req_valid(req_valid), .req_ready(req_ready),
        .req_tile(req_tile), .req_row(req_row), .skip_count(skip_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick = 0; cfg_we = 0; mask_we = 0; req_ready = 0; temp_hot = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input int t, input int iv);
        @(negedge clk);
        cfg_we = 1; cfg_tile = 4'(t); cfg_interval = 16'(iv);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic write_mask(input int t, input int r, input bit v);
        @(negedge clk);
        mask_we = 1; mask_tile = 4'(t); mask_row = 6'(r); mask_bit = v;
        @(negedge clk);
        mask_we = 0;
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic accept();
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
    endtask

    task automatic wait_req(input int t, input int r, input int hold, input string tag);
        int n = 0;
        while (!req_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(req_valid == 1'b1, {tag, " request present"}, int'(req_valid), 1);
        check(req_tile == 4'(t), {tag, " tile"}, int'(req_tile), t);
        check(req_row == 6'(r), {tag, " row"}, int'(req_row), r);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(req_valid && req_tile == 4'(t) && req_row == 6'(r), "R7 hold while not ready",
                  int'(req_row), r);
        end
        if (req_valid) accept();
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check(req_valid == 1'b0, "R1 req_valid after reset", int'(req_valid), 0);
        check(skip_count == 16'd0, "R1 skip_count after reset", int'(skip_count), 0);

        // R8: unprogrammed tile with a live row stays silent
        write_mask(4, 0, 1'b1);
        for (int i = 0; i < 20; i++) begin
            tick_pulse();
            repeat (4) @(negedge clk);
            check(req_valid == 1'b0, "R8 no request from unprogrammed tile", int'(req_valid), 0);
        end
        check(skip_count == 16'd0, "R8 no skips from unprogrammed tile", int'(skip_count), 0);

        // R2 / R3: interval sweep, cool and hot
        for (int h = 0; h < 2; h++) begin
            for (int iv = 0; iv <= 6; iv++) begin
                int eff;
                eff = (h != 0) ? (iv >> 1) : iv;
                if (eff == 0) eff = 1;
                do_reset();
                temp_hot[0] = 1'(h);
                write_mask(0, 0, 1'b1);
                write_cfg(0, iv);
                for (int t = 1; t <= eff; t++) begin
                    tick_pulse();
                    repeat (4) @(negedge clk);
                    if (h != 0)
                        check(req_valid == (t == eff), "R3 hot due tick", t, eff);
                    else
                        check(req_valid == (t == eff), "R2 due tick", t, eff);
                end
                if (req_valid) accept();
                repeat (80) @(negedge clk);
                check(skip_count == 16'd63, "R5 skips over one walk", int'(skip_count), 63);
                // periodic: next due again after eff ticks
                for (int t = 1; t <= eff; t++) begin
                    tick_pulse();
                    repeat (4) @(negedge clk);
                    check(req_valid == (t == eff), "R2 period repeats", t, eff);
                end
                if (req_valid) accept();
                repeat (80) @(negedge clk);
            end
        end

        // R4 / R5 / R7 / R9: ordered walk, hold, mask update
        do_reset();
        write_mask(3, 0, 1'b1);
        write_mask(3, 5, 1'b1);
        write_mask(3, 63, 1'b1);
        write_cfg(3, 2);
        tick_pulse();
        tick_pulse();
        wait_req(3, 0, 5, "R4 first live row");
        wait_req(3, 5, 0, "R4 second live row");
        wait_req(3, 63, 0, "R4 last live row");
        repeat (3) @(negedge clk);
        check(skip_count == 16'd61, "R5 skip count after walk", int'(skip_count), 61);
        write_mask(3, 5, 1'b0);
        tick_pulse();
        tick_pulse();
        wait_req(3, 0, 0, "R9 row 0 still live");
        wait_req(3, 63, 0, "R9 cleared row 5 passed over");
        repeat (3) @(negedge clk);
        check(skip_count == 16'd123, "R9 skip count after clear", int'(skip_count), 123);

        // R6: round robin with re-due tile
        do_reset();
        write_mask(2, 2, 1'b1);
        write_mask(5, 5, 1'b1);
        write_mask(9, 9, 1'b1);
        write_cfg(2, 1);
        write_cfg(5, 1);
        write_cfg(9, 1);
        tick_pulse();
        repeat (10) @(negedge clk);
        tick_pulse();
        wait_req(2, 2, 0, "R6 first grant tile 2");
        wait_req(5, 5, 0, "R6 next tile 5");
        wait_req(9, 9, 0, "R6 next tile 9");
        wait_req(2, 2, 0, "R6 tile 2 again last");
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (req_valid) break;
        end
        check(req_valid == 1'b0, "R6 no extra service", int'(req_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule